// File: doc/BRIEF.md
# Coded Frame Decoder and Classifier

This block sits behind a word-aligned receive path. Each cycle it may take one parallel frame: a data field of 16 or 20 bits and a 4-bit coding field. From the coding field alone it works out three things about the frame: whether it is a data frame or a control/fill frame, whether the sender complemented it, and, for data frames, the flag value. It restores the true data and recovers the flag. For control/fill frames, it first undoes any complement. It then inspects the two middle bits of the field to tell a control frame from a fill frame. If the frame is a control frame, it rebuilds the control word, whose two halves sit on either side of those middle bits.

Two mode inputs must match the far-end encoder. `wide_i` selects 20-bit or 16-bit fields. `flag_mode_i` selects how the flag bit is used. In flag mode the flag is user data. In error-checking mode the flag must alternate from one data frame to the next. An illegal coding field, or a flag that repeats in error-checking mode, raises a one-cycle error strobe. Every output is registered, so decoded results appear one clock after the input frame.

Top module: `frame_decoder`

## Requirements
- R1: Coding field 4'b1101 marks a true data frame with flag 0, and 4'b1011 marks a true data frame with flag 1. For either code, `data_o` equals the received field and `flag_o` carries the flag.
- R2: Coding field 4'b0010 marks a complemented data frame with flag 0, and 4'b0100 marks a complemented data frame with flag 1. For either code, `data_o` is the bitwise complement of the received field. In 16-bit mode, bits 19:16 of `data_o` are zero.
- R3: Any coding field other than the six legal values (1101, 1011, 0010, 0100, 0011, 1100) raises `err_o`, and neither `data_valid_o` nor `ctrl_valid_o` is raised for that frame.
- R4: Coding field 4'b0011 marks a true control/fill frame, and 4'b1100 marks a complemented one. A complemented frame is inverted before any further inspection. The frame is a control frame when the lower middle bit is 0 and the upper middle bit is 1; in that case `ctrl_valid_o` is raised. The middle bits are field bits 9 and 10 in 20-bit mode, and field bits 7 and 8 in 16-bit mode.
- R5: A control/fill frame whose middle bits (after any inversion) are 00, 11, or lower 1 / upper 0 is a fill frame. It raises no strobe and no error.
- R6: In 20-bit mode, `ctrl_word_o[8:0]` comes from field bits 8:0 and `ctrl_word_o[17:9]` comes from field bits 19:11.
- R7: In 16-bit mode, `ctrl_word_o[6:0]` comes from field bits 6:0, `ctrl_word_o[13:7]` comes from field bits 15:9, and `ctrl_word_o[17:14]` is zero.
- R8: In error-checking mode (`flag_mode_i`=0), a data frame whose flag equals the flag of the previous data frame since reset raises `err_o`, and its data is still delivered. The first data frame after reset never raises this error. Control, fill and illegal frames do not change the remembered flag.
- R9: In flag mode (`flag_mode_i`=1), a repeated flag never raises `err_o`.
- R10: Outputs are registered with one cycle of latency. Strobes are high only in the cycle after a valid frame. `data_o`/`flag_o` change only together with `data_valid_o`, and `ctrl_word_o` changes only together with `ctrl_valid_o`.
- R11: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: 20-bit fields, 0: 16-bit fields (bits 19:16 ignored) |
| flag_mode_i | input | 1 | 1: flag carries user data, 0: flag must alternate |
| frame_valid_i | input | 1 | A frame is present this cycle |
| frame_data_i | input | 20 | Received data field |
| frame_code_i | input | 4 | Received coding field |
| data_valid_o | output | 1 | Data frame decoded |
| data_o | output | 20 | Restored data word |
| flag_o | output | 1 | Recovered flag bit |
| ctrl_valid_o | output | 1 | Control frame decoded |
| ctrl_word_o | output | 18 | Rebuilt control word |
| err_o | output | 1 | Illegal code or repeated flag |

## Verification
On every cycle, the assertions check the properties that do not depend on frame contents. Data and control strobes never overlap, and a control strobe never comes with an error. No strobe appears without a frame in the previous cycle. The held outputs stay stable between their strobes, the upper data bits are zero in 16-bit mode, and a flag-repeat error only occurs in error-checking mode. Only the bench sweep can show that each coding value maps to the right polarity, flag and frame type. The same holds for the middle-bit split between control and fill frames, the bit packing of control words in both widths, and the flag alternation history across interleaved frame kinds.

// File: rtl/frame_dec_pkg.sv
package frame_dec_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CF   = 2'd1,
    KIND_BAD  = 2'd2
  } frame_kind_e;

  localparam logic [CODE_W-1:0] CODE_DATA_T0 = 4'b1101;
  localparam logic [CODE_W-1:0] CODE_DATA_I0 = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_DATA_T1 = 4'b1011;
  localparam logic [CODE_W-1:0] CODE_DATA_I1 = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_CF_T    = 4'b0011;
  localparam logic [CODE_W-1:0] CODE_CF_I    = 4'b1100;
endpackage

// File: rtl/frame_code_decode.sv
module frame_code_decode
  import frame_dec_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output frame_kind_e       kind_o,
  output logic              invert_o,
  output logic              flag_o
);
  always_comb begin
    kind_o   = KIND_BAD;
    invert_o = 1'b0;
    flag_o   = 1'b0;
    unique case (code_i)
      CODE_DATA_T0: kind_o = KIND_DATA;
      CODE_DATA_I0: begin kind_o = KIND_DATA; invert_o = 1'b1; end
      CODE_DATA_T1: begin kind_o = KIND_DATA; flag_o = 1'b1; end
      CODE_DATA_I1: begin kind_o = KIND_DATA; invert_o = 1'b1; flag_o = 1'b1; end
      CODE_CF_T:    kind_o = KIND_CF;
      CODE_CF_I:    begin kind_o = KIND_CF; invert_o = 1'b1; end
      default:      kind_o = KIND_BAD;
    endcase
  end
endmodule

// File: rtl/frame_field_unpack.sv
module frame_field_unpack #(
  parameter int unsigned W_WIDE   = 20,
  parameter int unsigned W_NARROW = 16,
  localparam int unsigned CW      = W_WIDE - 2
) (
  input  logic [W_WIDE-1:0] field_i,
  input  logic              wide_i,
  input  logic              invert_i,
  output logic [W_WIDE-1:0] data_o,
  output logic              is_ctrl_o,
  output logic [CW-1:0]     ctrl_word_o
);
  localparam int unsigned WM = W_WIDE / 2 - 1;   // lower middle bit, wide
  localparam int unsigned NM = W_NARROW / 2 - 1; // lower middle bit, narrow
  localparam int unsigned PAD = W_WIDE - W_NARROW;

  logic [W_WIDE-1:0] x;
  logic [CW-1:0]     word_w, word_n;
  logic              ctl_w, ctl_n;

  assign x = invert_i ? ~field_i : field_i;

  assign ctl_w  = ~x[WM] & x[WM+1];
  assign ctl_n  = ~x[NM] & x[NM+1];
  assign word_w = {x[W_WIDE-1:WM+2], x[WM-1:0]};
  assign word_n = {{PAD{1'b0}}, x[W_NARROW-1:NM+2], x[NM-1:0]};

  always_comb begin
    data_o = x;
    if (!wide_i) data_o[W_WIDE-1:W_NARROW] = '0;
  end

  assign is_ctrl_o   = wide_i ? ctl_w  : ctl_n;
  assign ctrl_word_o = wide_i ? word_w : word_n;
endmodule

// File: rtl/flag_seq_check.sv
module flag_seq_check (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_fire_i,
  input  logic flag_i,
  input  logic check_en_i,
  output logic seq_err_o
);
  logic prev_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (data_fire_i) begin
      prev_q <= flag_i;
      seen_q <= 1'b1;
    end
  end

  assign seq_err_o = data_fire_i & check_en_i & seen_q & (flag_i == prev_q);
endmodule

// File: rtl/frame_decoder.sv
module frame_decoder
  import frame_dec_pkg::*;
#(
  parameter int unsigned W_WIDE   = 20,
  parameter int unsigned W_NARROW = 16,
  localparam int unsigned CW      = W_WIDE - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              flag_mode_i,
  input  logic              frame_valid_i,
  input  logic [W_WIDE-1:0] frame_data_i,
  input  logic [CODE_W-1:0] frame_code_i,
  output logic              data_valid_o,
  output logic [W_WIDE-1:0] data_o,
  output logic              flag_o,
  output logic              ctrl_valid_o,
  output logic [CW-1:0]     ctrl_word_o,
  output logic              err_o
);
  frame_kind_e       kind;
  logic              invert, flag_d, is_ctrl, seq_err, data_fire, flag_mode_q;
  logic [W_WIDE-1:0] restored;
  logic [CW-1:0]     word;

  frame_code_decode u_code (
    .code_i(frame_code_i), .kind_o(kind), .invert_o(invert), .flag_o(flag_d)
  );

  frame_field_unpack #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) u_unpack (
    .field_i(frame_data_i), .wide_i(wide_i), .invert_i(invert),
    .data_o(restored), .is_ctrl_o(is_ctrl), .ctrl_word_o(word)
  );

  assign data_fire = frame_valid_i && (kind == KIND_DATA);

  flag_seq_check u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_fire_i(data_fire), .flag_i(flag_d),
    .check_en_i(~flag_mode_i), .seq_err_o(seq_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_valid_o <= 1'b0;
      data_o       <= '0;
      flag_o       <= 1'b0;
      ctrl_valid_o <= 1'b0;
      ctrl_word_o  <= '0;
      err_o        <= 1'b0;
      flag_mode_q  <= 1'b0;
    end else begin
      data_valid_o <= 1'b0;
      ctrl_valid_o <= 1'b0;
      err_o        <= 1'b0;
      flag_mode_q  <= flag_mode_i;
      if (frame_valid_i) begin
        unique case (kind)
          KIND_DATA: begin
            data_valid_o <= 1'b1;
            data_o       <= restored;
            flag_o       <= flag_d;
            err_o        <= seq_err;
          end
          KIND_CF: if (is_ctrl) begin
            ctrl_valid_o <= 1'b1;
            ctrl_word_o  <= word;
          end
          default: err_o <= 1'b1;
        endcase
      end
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_valid_o && ctrl_valid_o) && !(ctrl_valid_o && err_o));
  // R10
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !data_valid_o && !ctrl_valid_o && !err_o);
  // R10
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> $stable(data_o) && $stable(flag_o));
  // R10
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_valid_o |-> $stable(ctrl_word_o));
  // R2
  narrow_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i && !wide_i |=> !data_valid_o || data_o[W_WIDE-1:W_NARROW] == '0);
  // R9
  flag_mode_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o && err_o |-> !flag_mode_q);
endmodule

// File: tb/frame_decoder_tb.sv
module frame_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide = 1'b0, fmode = 1'b0, fv = 1'b0;
  logic [19:0] fdata = '0;
  logic [3:0]  fcode = '0;
  logic        dv, flg, cv, err;
  logic [19:0] dout;
  logic [17:0] cword;

  int checks = 0, fails = 0;
  logic prev_flag, have_prev;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  frame_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .flag_mode_i(fmode),
    .frame_valid_i(fv), .frame_data_i(fdata), .frame_code_i(fcode),
    .data_valid_o(dv), .data_o(dout), .flag_o(flg),
    .ctrl_valid_o(cv), .ctrl_word_o(cword), .err_o(err)
  );

  function automatic logic [19:0] pat(int p);
    case (p)
      0: return 20'h00000;
      1: return 20'hFFFFF;
      2: return 20'h00400;
      3: return 20'h00200;
      4: return 20'h00100;
      5: return 20'h00080;
      6: return 20'h5A3C7;
      default: return 20'hA5C38;
    endcase
  endfunction

  task automatic check(string req, logic [40:0] act, logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fv = 1'b0;
    have_prev = 1'b0;
    prev_flag = 1'b0;
    repeat (2) @(negedge clk);
    // R11
    check("R11 reset", {dv, cv, err, flg, dout, cword}, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(logic [3:0] c, logic [19:0] d);
    logic        e_dv = 0, e_cv = 0, e_err = 0, e_flag = 0, inv = 0;
    logic [19:0] e_data = '0, x;
    logic [17:0] e_word = '0;
    string       req = "R5 fill";
    case (c)
      4'b1101: begin e_dv = 1; req = "R1 true data"; end
      4'b1011: begin e_dv = 1; e_flag = 1; req = "R1 true data"; end
      4'b0010: begin e_dv = 1; inv = 1; req = "R2 inverted data"; end
      4'b0100: begin e_dv = 1; e_flag = 1; inv = 1; req = "R2 inverted data"; end
      4'b0011: ;
      4'b1100: inv = 1;
      default: begin e_err = 1; req = "R3 illegal code"; end
    endcase
    x = inv ? ~d : d;
    if (e_dv) begin
      e_data = wide ? x : (x & 20'h0FFFF);
      if (!fmode && have_prev && prev_flag == e_flag) begin
        e_err = 1;
        req = "R8 repeated flag";
      end
      have_prev = 1;
      prev_flag = e_flag;
    end else if (c == 4'b0011 || c == 4'b1100) begin
      if (wide && !x[9] && x[10]) begin
        e_cv = 1;
        e_word = 18'(x[8:0]) + (18'(x[19:11]) << 9);
        req = "R4 R6 wide control";
      end else if (!wide && !x[7] && x[8]) begin
        e_cv = 1;
        e_word = 18'(x[6:0]) + (18'(x[15:9]) << 7);
        req = "R4 R7 narrow control";
      end
    end
    fcode = c;
    fdata = d;
    fv = 1'b1;
    @(negedge clk);
    fv = 1'b0;
    // R10: outputs one cycle after the frame
    check(req, {dv, cv, err}, {e_dv, e_cv, e_err});
    if (e_dv) check({req, " R9 data/flag"}, {flg, dout}, {e_flag, e_data});
    if (e_cv) check(req, 41'(cword), 41'(e_word));
    @(negedge clk);
    // R10: strobes last one cycle
    check("R10 idle", {dv, cv, err}, 3'b000);
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      wide = m[0];
      fmode = m[1];
      do_reset();
      for (int c = 0; c < 16; c++)
        for (int p = 0; p < 8; p++)
          send(4'(c), pat(p));
    end
    // R8: alternation with control/fill/illegal frames in between
    wide = 1'b1;
    fmode = 1'b0;
    do_reset();
    send(4'b1101, 20'h12345);
    send(4'b0011, 20'h00400);
    send(4'b1111, 20'h00000);
    send(4'b0011, 20'h00000);
    send(4'b0100, 20'h0F0F0);
    send(4'b1011, 20'h0F0F0);
    send(4'b0010, 20'h33333);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule